// File: doc/BRIEF.md
# Pipelined Multiply-Add Unit

This block multiplies two 64-bit integers and combines the full 128-bit product with a 128-bit addend. A control flag chooses between adding the product to the addend and subtracting it from the addend. A second flag chooses whether the two operands are read as two's-complement or as unsigned values. The addend is always a raw 128-bit value, and the arithmetic wraps modulo 2^128.

The unit can take a new request in every cycle. A request that is captured at a rising edge gives its 128-bit result two cycles later, marked by a result strobe. One cycle after that, a second strobe marks a flag that tells whether the result would overflow a 64-bit destination of the selected signedness. Inside, the product is formed from a grid of narrower partial products. Partial products that can be negative are sign-extended, and the sum is made in a second pipeline stage. Every data register is updated only when a valid operation passes through it, so idle stages keep their values.

Top module: `mul_add_unit`

## Requirements
- R1: With sub_mode=0 and sgn_mode=0, result equals (addend + op_a*op_b) mod 2^128, with both operands taken as unsigned.
- R2: With sub_mode=1, result equals (addend - op_a*op_b) mod 2^128.
- R3: With sgn_mode=1, op_a and op_b are taken as two's-complement 64-bit values. For example, all-ones times all-ones gives a product of 1.
- R4: A request accepted at a rising edge with in_valid=1 produces out_valid=1, with its result, for exactly the cycle that follows the second rising edge after it.
- R5: Requests on consecutive cycles are all accepted. Their results come out on consecutive cycles in request order.
- R6: With sgn_mode=0, ovf is 1 exactly when result bits [127:64] are not all zero.
- R7: With sgn_mode=1, ovf is 1 exactly when result bits [127:63] are not all equal.
- R8: The ovf value for a request is presented with ovf_valid=1 in the cycle after that request's out_valid.
- R9: When in_valid is 0, the inputs have no effect. No strobe is raised, and result keeps its last value.
- R10: While rst_n is low, out_valid, ovf_valid, ovf and result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First multiplicand |
| op_b | input | 64 | Second multiplicand |
| addend | input | 128 | Value the product is added to or subtracted from |
| sgn_mode | input | 1 | 1: operands are two's complement; 0: unsigned |
| sub_mode | input | 1 | 1: addend minus product; 0: addend plus product |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Product combined with addend |
| ovf_valid | output | 1 | Overflow flag strobe |
| ovf | output | 1 | 64-bit overflow of the result |

## Verification
The assertions watch strobe timing on every cycle: a request is followed by out_valid two edges later, and out_valid is followed by ovf_valid. They also check that result holds while no result strobe is present. They check the overflow flag against the previous result whenever that result either clearly fits or has mixed upper bits. Only the bench's scenarios can show the arithmetic itself. These cover corner operands such as the most negative value and all-ones in both signedness modes, add and subtract, back-to-back ordering, and the fact that idle inputs are ignored.

// File: rtl/mad_pkg.sv
package mad_pkg;
  localparam int MAD_DATA_W  = 64;
  localparam int MAD_CHUNK_W = 32;

  typedef struct packed {
    logic sgn;
    logic sub;
  } mad_ctl_t;
endpackage

// File: rtl/mad_rst_sync.sv
module mad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mad_pp_grid.sv
// Splits each operand into CHUNK_W-bit slices. The top slice gets an extra
// sign bit in signed mode, and the lower slices get a zero bit. Each slice
// product is sign-extended to the full width and shifted into place.
module mad_pp_grid #(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 32,
  localparam int RES_W  = 2 * DATA_W,
  localparam int NC     = DATA_W / CHUNK_W,
  localparam int NPP    = NC * NC
) (
  input  logic [DATA_W-1:0]           a,
  input  logic [DATA_W-1:0]           b,
  input  logic                        sgn,
  output logic [NPP-1:0][RES_W-1:0]   pp
);
  localparam int PW = 2 * CHUNK_W + 2;

  for (genvar i = 0; i < NC; i++) begin : g_row
    for (genvar j = 0; j < NC; j++) begin : g_col
      logic                 xa_top, xb_top;
      logic signed [PW-1:0] sa, sb, prod;
      logic [RES_W-1:0]     ext;

      if (i == NC - 1) begin : g_atop
        assign xa_top = sgn & a[DATA_W-1];
      end else begin : g_alow
        assign xa_top = 1'b0;
      end
      if (j == NC - 1) begin : g_btop
        assign xb_top = sgn & b[DATA_W-1];
      end else begin : g_blow
        assign xb_top = 1'b0;
      end

      assign sa   = {{(PW-CHUNK_W){xa_top}}, a[i*CHUNK_W +: CHUNK_W]};
      assign sb   = {{(PW-CHUNK_W){xb_top}}, b[j*CHUNK_W +: CHUNK_W]};
      assign prod = sa * sb;
      assign ext  = {{(RES_W-PW){prod[PW-1]}}, prod};
      assign pp[i*NC+j] = ext << ((i + j) * CHUNK_W);
    end
  end
endmodule

// File: rtl/mad_accum.sv
module mad_accum #(
  parameter int RES_W = 128,
  parameter int NPP   = 4
) (
  input  logic [NPP-1:0][RES_W-1:0] pp,
  input  logic [RES_W-1:0]          base,
  input  logic                      sub,
  output logic [RES_W-1:0]          sum
);
  logic [RES_W-1:0] prod;

  always_comb begin
    prod = '0;
    for (int k = 0; k < NPP; k++) prod = prod + pp[k];
  end

  assign sum = sub ? (base - prod) : (base + prod);
endmodule

// File: rtl/mad_ovf_det.sv
module mad_ovf_det #(
  parameter int DATA_W = 64,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic [RES_W-1:0] res,
  input  logic             sgn,
  output logic             ovf
);
  logic [RES_W-DATA_W:0] hi_s;
  logic                  s_ovf, u_ovf;

  assign hi_s  = res[RES_W-1:DATA_W-1];
  assign s_ovf = !((&hi_s) | (~|hi_s));
  assign u_ovf = |res[RES_W-1:DATA_W];
  assign ovf   = sgn ? s_ovf : u_ovf;
endmodule

// File: rtl/mul_add_unit.sv
module mul_add_unit #(
  parameter int DATA_W  = mad_pkg::MAD_DATA_W,
  parameter int CHUNK_W = mad_pkg::MAD_CHUNK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     op_a,
  input  logic [DATA_W-1:0]     op_b,
  input  logic [2*DATA_W-1:0]   addend,
  input  logic                  sgn_mode,
  input  logic                  sub_mode,
  output logic                  out_valid,
  output logic [2*DATA_W-1:0]   result,
  output logic                  ovf_valid,
  output logic                  ovf
);
  import mad_pkg::*;

  localparam int RES_W = 2 * DATA_W;
  localparam int NC    = DATA_W / CHUNK_W;
  localparam int NPP   = NC * NC;

  logic rst_n_sync;

  mad_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Stage 1: partial products
  logic [NPP-1:0][RES_W-1:0] pp_w;
  logic [NPP-1:0][RES_W-1:0] s1_pp_q, s1_pp_d;
  logic [RES_W-1:0]          s1_c_q, s1_c_d;
  mad_ctl_t                  s1_ctl_q, s1_ctl_d;
  logic                      s1_vld_q, s1_vld_d;

  mad_pp_grid #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_grid (
    .a   (op_a),
    .b   (op_b),
    .sgn (sgn_mode),
    .pp  (pp_w)
  );

  always_comb begin
    s1_vld_d = in_valid;
    if (in_valid) begin
      s1_pp_d  = pp_w;
      s1_c_d   = addend;
      s1_ctl_d = '{sgn: sgn_mode, sub: sub_mode};
    end else begin
      s1_pp_d  = s1_pp_q;
      s1_c_d   = s1_c_q;
      s1_ctl_d = s1_ctl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      s1_vld_q <= 1'b0;
      s1_pp_q  <= '0;
      s1_c_q   <= '0;
      s1_ctl_q <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_pp_q  <= s1_pp_d;
      s1_c_q   <= s1_c_d;
      s1_ctl_q <= s1_ctl_d;
    end
  end

  // Stage 2: summation and add/subtract
  logic [RES_W-1:0] sum_w;
  logic [RES_W-1:0] s2_res_q, s2_res_d;
  logic             s2_sgn_q, s2_sgn_d;
  logic             s2_vld_q, s2_vld_d;

  mad_accum #(.RES_W(RES_W), .NPP(NPP)) u_accum (
    .pp   (s1_pp_q),
    .base (s1_c_q),
    .sub  (s1_ctl_q.sub),
    .sum  (sum_w)
  );

  always_comb begin
    s2_vld_d = s1_vld_q;
    if (s1_vld_q) begin
      s2_res_d = sum_w;
      s2_sgn_d = s1_ctl_q.sgn;
    end else begin
      s2_res_d = s2_res_q;
      s2_sgn_d = s2_sgn_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      s2_vld_q <= 1'b0;
      s2_res_q <= '0;
      s2_sgn_q <= 1'b0;
    end else begin
      s2_vld_q <= s2_vld_d;
      s2_res_q <= s2_res_d;
      s2_sgn_q <= s2_sgn_d;
    end
  end

  // Stage 3: overflow flag
  logic ovf_w;
  logic s3_ovf_q, s3_ovf_d;
  logic s3_vld_q, s3_vld_d;

  mad_ovf_det #(.DATA_W(DATA_W)) u_ovf (
    .res (s2_res_q),
    .sgn (s2_sgn_q),
    .ovf (ovf_w)
  );

  always_comb begin
    s3_vld_d = s2_vld_q;
    s3_ovf_d = s2_vld_q ? ovf_w : s3_ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      s3_vld_q <= 1'b0;
      s3_ovf_q <= 1'b0;
    end else begin
      s3_vld_q <= s3_vld_d;
      s3_ovf_q <= s3_ovf_d;
    end
  end

  assign out_valid = s2_vld_q;
  assign result    = s2_res_q;
  assign ovf_valid = s3_vld_q;
  assign ovf       = s3_ovf_q;
endmodule

// File: rtl/mad_chk.sv
module mad_chk #(
  parameter int DATA_W = 64,
  localparam int RES_W = 2 * DATA_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [RES_W-1:0] result,
  input logic             ovf_valid,
  input logic             ovf
);
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r8_ovf_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> ovf_valid);

  a_r8_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> $past(out_valid));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));

  // R6 and R7: a result that fits in both views never overflows
  a_r6_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_valid && $past(result[RES_W-1:DATA_W-1] == '0)) |-> !ovf);

  // R6 and R7: mixed upper bits overflow in either mode
  a_r7_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_valid && $past(result[RES_W-1:DATA_W] != '0 &&
                        result[RES_W-1:DATA_W] != '1)) |-> ovf);
endmodule

bind mul_add_unit mad_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .result    (result),
  .ovf_valid (ovf_valid),
  .ovf       (ovf)
);

// File: tb/mul_add_unit_tb.sv
module mul_add_unit_tb;
  localparam int NT = 10;
  localparam int NR = 40;
  localparam int NV = NT + NR;
  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  // {op_a, op_b, addend, sgn, sub}
  localparam logic [257:0] VTAB [NT] = '{
    {64'd3,  64'd5,           128'd7,             1'b0, 1'b0},
    {ONES,   ONES,            128'd0,             1'b0, 1'b0},
    {ONES,   ONES,            128'd0,             1'b1, 1'b0},
    {MINV,   MINV,            128'd0,             1'b1, 1'b0},
    {MINV,   ONES,            128'd0,             1'b1, 1'b0},
    {MINV,   64'd1,           128'd0,             1'b1, 1'b1},
    {64'd0,  ONES,            {ONES, ONES},       1'b0, 1'b0},
    {64'd0,  ONES,            {ONES, ONES},       1'b1, 1'b0},
    {64'd1,  ONES,            128'd5,             1'b1, 1'b1},
    {64'h1_0000_0000, 64'h1_0000_0000, 128'd0,    1'b0, 1'b0}
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [63:0]  op_a, op_b;
  logic [127:0] addend;
  logic         sgn_mode, sub_mode;
  logic         out_valid, ovf_valid, ovf;
  logic [127:0] result;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit mon_en = 0;
  int out_cnt = 0;
  int ovf_cnt = 0;

  logic [63:0]  st_a [NV];
  logic [63:0]  st_b [NV];
  logic [127:0] st_c [NV];
  logic         st_s [NV];
  logic         st_u [NV];
  logic [127:0] ex_res [NV];
  logic         ex_ovf [NV];

  mul_add_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .addend    (addend),
    .sgn_mode  (sgn_mode),
    .sub_mode  (sub_mode),
    .out_valid (out_valid),
    .result    (result),
    .ovf_valid (ovf_valid),
    .ovf       (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [127:0] ref_res(logic [63:0] a, logic [63:0] b,
                                           logic [127:0] c, logic s, logic u);
    logic [127:0] ea, eb, p;
    ea = s ? {{64{a[63]}}, a} : {64'd0, a};
    eb = s ? {{64{b[63]}}, b} : {64'd0, b};
    p  = ea * eb;
    return u ? (c - p) : (c + p);
  endfunction

  function automatic logic ref_ovf(logic [127:0] r, logic s);
    if (s) return !((r[127:63] == '0) || (r[127:63] == '1));
    return r[127:64] != '0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Streaming monitor (R1, R2, R3, R5, R6, R7)
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      if (out_cnt < NV)
        check(result === ex_res[out_cnt],
              st_u[out_cnt] ? "R2" : (st_s[out_cnt] ? "R3" : "R1"),
              result, ex_res[out_cnt]);
      out_cnt++;
    end
    if (mon_en && ovf_valid) begin
      if (ovf_cnt < NV)
        check(ovf === ex_ovf[ovf_cnt], st_s[ovf_cnt] ? "R7" : "R6",
              {127'd0, ovf}, {127'd0, ex_ovf[ovf_cnt]});
      ovf_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [127:0] held, er;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; addend = '0;
    sgn_mode = 1'b0; sub_mode = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (i < NT) begin
        {st_a[i], st_b[i], st_c[i], st_s[i], st_u[i]} = VTAB[i];
      end else begin
        st_a[i] = {$urandom, $urandom};
        st_b[i] = (i % 3 == 0) ? {{48{st_a[i][5]}}, 16'($urandom)}
                               : {$urandom, $urandom};
        st_c[i] = (i % 4 == 0) ? 128'd0 : {$urandom, $urandom, $urandom, $urandom};
        st_s[i] = i[0];
        st_u[i] = i[1];
      end
      ex_res[i] = ref_res(st_a[i], st_b[i], st_c[i], st_s[i], st_u[i]);
      ex_ovf[i] = ref_ovf(ex_res[i], st_s[i]);
    end

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", {127'd0, out_valid}, 128'd0);
    check(ovf_valid === 1'b0, "R10", {127'd0, ovf_valid}, 128'd0);
    check(ovf === 1'b0,       "R10", {127'd0, ovf}, 128'd0);
    check(result === 128'd0,  "R10", result, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1, R2, R3, R5: back-to-back stream
    mon_en = 1;
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1; op_a = st_a[i]; op_b = st_b[i]; addend = st_c[i];
      sgn_mode = st_s[i]; sub_mode = st_u[i];
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    mon_en = 0;
    check(out_cnt == NV, "R5", 128'(out_cnt), 128'(NV));
    check(ovf_cnt == NV, "R8", 128'(ovf_cnt), 128'(NV));

    // R9: inputs without in_valid are ignored
    held = result;
    for (int k = 0; k < 6; k++) begin
      op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
      addend = {$urandom, $urandom, $urandom, $urandom};
      sgn_mode = k[0]; sub_mode = k[1];
      @(negedge clk);
      check(out_valid === 1'b0 && ovf_valid === 1'b0, "R9",
            {126'd0, out_valid, ovf_valid}, 128'd0);
      check(result === held, "R9", result, held);
    end

    // R4, R8: exact latency of result and overflow strobes
    er = ref_res(MINV, MINV, 128'd0, 1'b1, 1'b0);
    in_valid = 1'b1; op_a = MINV; op_b = MINV; addend = '0;
    sgn_mode = 1'b1; sub_mode = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b0, "R4", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    check(out_valid === 1'b1, "R4", {127'd0, out_valid}, 128'd1);
    check(result === er, "R4", result, er);
    check(ovf_valid === 1'b0, "R8", {127'd0, ovf_valid}, 128'd0);
    @(negedge clk);
    check(out_valid === 1'b0, "R4", {127'd0, out_valid}, 128'd0);
    check(ovf_valid === 1'b1, "R8", {127'd0, ovf_valid}, 128'd1);
    check(ovf === 1'b1, "R7", {127'd0, ovf}, 128'd1);
    @(negedge clk);
    check(ovf_valid === 1'b0, "R8", {127'd0, ovf_valid}, 128'd0);

    // R10: reset asserted again clears outputs at once
    rst_n = 1'b0;
    #1;
    check(result === 128'd0 && ovf === 1'b0, "R10", result, 128'd0);
    @(negedge clk);
    summary();
  end
endmodule